// File: doc/BRIEF.md
# Banked Stack Pointer Bank with Limit Checking

This block keeps the stack pointers of a processor core that has two security states. Each state has a main stack and a process stack. Each of those four pointers has its own lower limit register. Each state also has its own stack-select bit. The current security state, the execution mode (handler or thread) and that state's select bit together choose the active pointer. The active pointer's value is always visible on `active_sp_o`.

Software reaches the registers through a select/write-data/read-data port that behaves like the move-to and move-from special-register operations. In Non-secure state the plain selectors reach the Non-secure copies. In Secure state, alias selectors let software reach the Non-secure copies as well.

Stack operations arrive on a valid/ready stream. Each transfer names a push or a pop and a word count. The block updates the active pointer. If the lowest address touched falls below the active limit, it suppresses the update and pulses a fault instead. `op_ready_o` drops in any cycle in which a register write is presented, so a write always wins over a stack operation. A transfer completes only when `op_valid_i` and `op_ready_o` are both high. The producer must hold the transfer until that happens.

Top module: `stack_bank_ctrl`

## Requirements
- R1: In handler mode (`handler_i`=1) the active pointer is the main pointer of the current security state, whatever the select bits hold.
- R2: In thread mode the active pointer is the current state's process pointer when that state's select bit is 1, and its main pointer when the bit is 0. The select bit is written and read as bit 1 of the control selector, and each state has its own bit.
- R3: After reset all four pointers, all four limits and both select bits are zero, and `fault_o` is low.
- R4: Selector codes for the current state are 0 = main pointer, 1 = process pointer, 2 = main limit, 3 = process limit, 4 = control. Codes 8 to 12 address the same registers of the Non-secure copy and work only in Secure state (`sec_i`=1). Reads are combinational on `reg_rdata_o`, and writes take effect at the clock edge.
- R5: In Non-secure state, selector codes 8 to 12 are ignored on write and read as zero. Codes 5 to 7 and 13 to 15 read as zero in either state and change nothing.
- R6: Every write to a pointer stores the written value with bits [1:0] forced to zero.
- R7: A push of N words (N = `op_words_i`) moves the active pointer to pointer - 4N. It faults when that result is below the active limit, or when 4N exceeds the pointer. A pop checks the current pointer against the active limit and moves the pointer to pointer + 4N, wrapping modulo 2^AW.
- R8: A faulting operation leaves every pointer unchanged and raises `fault_o` for exactly the cycle after the transfer. `fault_o` is never high without a transfer in the previous cycle.
- R9: With `HAS_NS_LIM`=0, the Non-secure limits read as zero, ignore writes, and Non-secure-state operations never fault, including on wrap.
- R10: `op_ready_o` equals the inverse of `reg_we_i`. An operation presented together with a register write is not performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_i | input | 1 | Current security state, 1 = Secure |
| handler_i | input | 1 | Current mode, 1 = handler, 0 = thread |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 4 | Register selector code |
| reg_wdata_i | input | AW | Register write data |
| reg_rdata_o | output | AW | Register read data for `reg_sel_i` |
| op_valid_i | input | 1 | Stack operation valid |
| op_ready_o | output | 1 | Stack operation ready |
| op_push_i | input | 1 | 1 = push, 0 = pop |
| op_words_i | input | WW | Number of words moved |
| active_sp_o | output | AW | Value of the active pointer |
| fault_o | output | 1 | One-cycle limit fault pulse |

## Verification
The hardest case to reach is a fault that lands exactly on the limit boundary, or that comes only from wrap-around below address zero. Random pointer values alone rarely meet a limit at the right distance. The stimulus therefore draws pointers and limits from a narrow shared window and keeps some pointers close to zero, so that both the limit comparison and the borrow path fire often. Directed pushes then land exactly on the limit and one word below it. The Non-secure copies are reached both through the aliases from Secure state and natively from Non-secure state. A second instance built without Non-secure limits shows that limit faults and wrap faults are both absent there.

// File: rtl/stkb_pkg.sv
package stkb_pkg;
  // Target kind of a register access after selector decode
  typedef enum logic [1:0] {K_SP, K_LIM, K_CTL, K_NONE} kind_e;

  // Field codes in reg_sel[2:0]; reg_sel[3] selects the Non-secure alias
  localparam logic [2:0] F_MAIN  = 3'd0;
  localparam logic [2:0] F_PROC  = 3'd1;
  localparam logic [2:0] F_MLIM  = 3'd2;
  localparam logic [2:0] F_PLIM  = 3'd3;
  localparam logic [2:0] F_CTL   = 3'd4;

  // Bank index: {secure, process}
  localparam int NBANK = 4;
endpackage

// File: rtl/stkb_decode.sv
module stkb_decode
  import stkb_pkg::*;
(
  input  logic       sec,
  input  logic [3:0] sel,
  output kind_e      kind,
  output logic [1:0] bank
);
  logic tgt_sec;
  logic proc;

  always_comb begin
    tgt_sec = sel[3] ? 1'b0 : sec;
    proc    = 1'b0;
    kind    = K_NONE;
    case (sel[2:0])
      F_MAIN: kind = K_SP;
      F_PROC: begin kind = K_SP;  proc = 1'b1; end
      F_MLIM: kind = K_LIM;
      F_PLIM: begin kind = K_LIM; proc = 1'b1; end
      F_CTL:  kind = K_CTL;
      default: kind = K_NONE;
    endcase
    // Alias selectors are only honoured from Secure state
    if (sel[3] && !sec) kind = K_NONE;
    bank = {tgt_sec, proc};
  end
endmodule

// File: rtl/stkb_regs.sv
module stkb_regs
  import stkb_pkg::*;
#(
  parameter int AW         = 32,
  parameter bit HAS_NS_LIM = 1'b1
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  kind_e                   cfg_kind,
  input  logic [1:0]              cfg_bank,
  input  logic [AW-1:0]           cfg_wdata,
  input  logic                    upd_en,
  input  logic [1:0]              upd_bank,
  input  logic [AW-1:0]           upd_sp,
  output logic [NBANK-1:0][AW-1:0] sp_o,
  output logic [NBANK-1:0][AW-1:0] lim_o,
  output logic [1:0]              spsel_o
);
  logic [AW-1:0] sp_q  [NBANK];
  logic [AW-1:0] lim_q [NBANK];
  logic          sel_q [2];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n)
        sp_q[b] <= '0;
      else if (cfg_we && cfg_kind == K_SP && cfg_bank == 2'(b))
        sp_q[b] <= {cfg_wdata[AW-1:2], 2'b00};
      else if (upd_en && upd_bank == 2'(b))
        sp_q[b] <= upd_sp;
    end
    assign sp_o[b] = sp_q[b];

    if (b >= 2 || HAS_NS_LIM) begin : g_lim
      always_ff @(posedge clk) begin
        if (!rst_n)
          lim_q[b] <= '0;
        else if (cfg_we && cfg_kind == K_LIM && cfg_bank == 2'(b))
          lim_q[b] <= cfg_wdata;
      end
    end else begin : g_nolim
      assign lim_q[b] = '0;
    end
    assign lim_o[b] = lim_q[b];

    // Stored pointers keep word alignment through writes and stack moves
    assert_sp_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sp_q[b][1:0] == 2'b00);
  end

  for (genvar s = 0; s < 2; s++) begin : g_sel
    always_ff @(posedge clk) begin
      if (!rst_n)
        sel_q[s] <= 1'b0;
      else if (cfg_we && cfg_kind == K_CTL && cfg_bank[1] == 1'(s))
        sel_q[s] <= cfg_wdata[1];
    end
    assign spsel_o[s] = sel_q[s];
  end
endmodule

// File: rtl/stkb_limchk.sv
module stkb_limchk
  import stkb_pkg::*;
#(
  parameter int AW         = 32,
  parameter int WW         = 4,
  parameter bit HAS_NS_LIM = 1'b1
)(
  input  logic [NBANK-1:0][AW-1:0] sp,
  input  logic [NBANK-1:0][AW-1:0] lim,
  input  logic                     push,
  input  logic [WW-1:0]            words,
  output logic [NBANK-1:0][AW-1:0] nxt,
  output logic [NBANK-1:0]         flt
);
  localparam int PADW = AW - WW - 2;
  logic [AW-1:0] step;
  assign step = {{PADW{1'b0}}, words, 2'b00};

  for (genvar b = 0; b < NBANK; b++) begin : g_cmp
    logic [AW:0] diff;
    logic        lim_hit;
    assign diff = {1'b0, sp[b]} - {1'b0, step};
    always_comb begin
      if (push) begin
        nxt[b]  = diff[AW-1:0];
        lim_hit = diff[AW] | (diff[AW-1:0] < lim[b]);
      end else begin
        nxt[b]  = sp[b] + step;
        lim_hit = sp[b] < lim[b];
      end
    end
    if (b >= 2 || HAS_NS_LIM) begin : g_on
      assign flt[b] = lim_hit;
    end else begin : g_off
      assign flt[b] = 1'b0;
    end
  end
endmodule

// File: rtl/stkb_select.sv
module stkb_select (
  input  logic       sec,
  input  logic       handler,
  input  logic [1:0] spsel,
  output logic [1:0] act_bank
);
  assign act_bank = {sec, ~handler & spsel[sec]};
endmodule

// File: rtl/stack_bank_ctrl.sv
module stack_bank_ctrl
  import stkb_pkg::*;
#(
  parameter int AW         = 32,
  parameter int WW         = 4,
  parameter bit HAS_NS_LIM = 1'b1
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_i,
  input  logic          handler_i,
  input  logic          reg_we_i,
  input  logic [3:0]    reg_sel_i,
  input  logic [AW-1:0] reg_wdata_i,
  output logic [AW-1:0] reg_rdata_o,
  input  logic          op_valid_i,
  output logic          op_ready_o,
  input  logic          op_push_i,
  input  logic [WW-1:0] op_words_i,
  output logic [AW-1:0] active_sp_o,
  output logic          fault_o
);
  kind_e                    acc_kind;
  logic [1:0]               acc_bank;
  logic [1:0]               act_bank;
  logic [NBANK-1:0][AW-1:0] sp_w, lim_w, nxt_w;
  logic [NBANK-1:0]         flt_w;
  logic [1:0]               spsel_w;
  logic                     op_fire, fault_sel, fault_q;

  stkb_decode u_dec (.sec(sec_i), .sel(reg_sel_i), .kind(acc_kind), .bank(acc_bank));

  stkb_select u_sel (.sec(sec_i), .handler(handler_i), .spsel(spsel_w), .act_bank(act_bank));

  stkb_regs #(.AW(AW), .HAS_NS_LIM(HAS_NS_LIM)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(reg_we_i), .cfg_kind(acc_kind), .cfg_bank(acc_bank), .cfg_wdata(reg_wdata_i),
    .upd_en(op_fire && !fault_sel), .upd_bank(act_bank), .upd_sp(nxt_w[act_bank]),
    .sp_o(sp_w), .lim_o(lim_w), .spsel_o(spsel_w)
  );

  stkb_limchk #(.AW(AW), .WW(WW), .HAS_NS_LIM(HAS_NS_LIM)) u_chk (
    .sp(sp_w), .lim(lim_w), .push(op_push_i), .words(op_words_i),
    .nxt(nxt_w), .flt(flt_w)
  );

  // Register writes win over stack operations
  assign op_ready_o  = ~reg_we_i;
  assign op_fire     = op_valid_i & op_ready_o;
  assign fault_sel   = flt_w[act_bank];
  assign active_sp_o = sp_w[act_bank];

  always_ff @(posedge clk) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= op_fire & fault_sel;
  end
  assign fault_o = fault_q;

  always_comb begin
    case (acc_kind)
      K_SP:    reg_rdata_o = sp_w[acc_bank];
      K_LIM:   reg_rdata_o = lim_w[acc_bank];
      K_CTL:   reg_rdata_o = AW'({spsel_w[acc_bank[1]], 1'b0});
      default: reg_rdata_o = '0;
    endcase
  end

  assert_handler_main_R1: assert property (@(posedge clk) disable iff (!rst_n)
    handler_i |-> (act_bank[0] == 1'b0 && act_bank[1] == sec_i));

  assert_fault_after_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> $past(op_valid_i && !reg_we_i));

  assert_fault_no_move_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_fire && fault_sel) |=> (sp_w == $past(sp_w)));

  assert_alias_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_i && !sec_i && reg_sel_i[3]) |=>
      (sp_w == $past(sp_w) && lim_w == $past(lim_w) && spsel_w == $past(spsel_w)));
endmodule

// File: tb/tb_stack_bank_ctrl.sv
module tb_stack_bank_ctrl;
  localparam int AW = 32;
  localparam int WW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sec = 1'b0, hnd = 1'b0, we = 1'b0, ov = 1'b0, push = 1'b0;
  logic [3:0] sel = '0;
  logic [AW-1:0] wd = '0;
  logic [WW-1:0] words = '0;
  logic [AW-1:0] rdata, asp, rdata_nl, asp_nl;
  logic ready, fault, ready_nl, fault_nl;

  int checks = 0, errors = 0;
  logic [AW-1:0] m_sp [4];
  logic [AW-1:0] m_lim [4];
  logic          m_sel [2];

  always #5 clk = ~clk;

  stack_bank_ctrl #(.AW(AW), .WW(WW), .HAS_NS_LIM(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .sec_i(sec), .handler_i(hnd), .reg_we_i(we),
    .reg_sel_i(sel), .reg_wdata_i(wd), .reg_rdata_o(rdata), .op_valid_i(ov),
    .op_ready_o(ready), .op_push_i(push), .op_words_i(words),
    .active_sp_o(asp), .fault_o(fault));

  stack_bank_ctrl #(.AW(AW), .WW(WW), .HAS_NS_LIM(1'b0)) dut_nl (
    .clk(clk), .rst_n(rst_n), .sec_i(sec), .handler_i(hnd), .reg_we_i(we),
    .reg_sel_i(sel), .reg_wdata_i(wd), .reg_rdata_o(rdata_nl), .op_valid_i(ov),
    .op_ready_o(ready_nl), .op_push_i(push), .op_words_i(words),
    .active_sp_o(asp_nl), .fault_o(fault_nl));

  task automatic chk(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected read value for a selector in a state (R4, R5, R2)
  function automatic logic [AW-1:0] exp_read(input logic s, input logic [3:0] c);
    logic t;
    t = c[3] ? 1'b0 : s;
    if (c[3] && !s) return '0;
    case (c[2:0])
      3'd0: return m_sp[{t, 1'b0}];
      3'd1: return m_sp[{t, 1'b1}];
      3'd2: return m_lim[{t, 1'b0}];
      3'd3: return m_lim[{t, 1'b1}];
      3'd4: return AW'({m_sel[t], 1'b0});
      default: return '0;
    endcase
  endfunction

  function automatic logic [1:0] exp_bank(input logic s, input logic h);
    return {s, ~h & m_sel[s]};
  endfunction

  task automatic rd(input logic s, input logic [3:0] c, input string req);
    @(negedge clk);
    sec = s; sel = c; we = 1'b0; ov = 1'b0;
    #1 chk(rdata === exp_read(s, c), req, rdata, exp_read(s, c));
  endtask

  // One clock of stimulus, model update and checks (R1 R2 R7 R8 R10)
  task automatic step(input logic s, input logic h, input logic w, input logic [3:0] c,
                      input logic [AW-1:0] d, input logic v, input logic p, input logic [WW-1:0] n);
    logic [1:0] b;
    logic [AW-1:0] stp, nsp;
    logic ef, t;
    @(negedge clk);
    sec = s; hnd = h; we = w; sel = c; wd = d; ov = v; push = p; words = n;
    #1 chk(ready === ~w, "R10 ready", AW'(ready), AW'(~w));
    b = exp_bank(s, h);
    ef = 1'b0; nsp = m_sp[b];
    stp = AW'(n) * 4;
    if (v && !w) begin
      if (p) begin
        nsp = m_sp[b] - stp;
        ef = (stp > m_sp[b]) || (nsp < m_lim[b]);
      end else begin
        nsp = m_sp[b] + stp;
        ef = m_sp[b] < m_lim[b];
      end
    end
    @(posedge clk); #1;
    if (w && !(c[3] && !s)) begin
      t = c[3] ? 1'b0 : s;
      case (c[2:0])
        3'd0: m_sp[{t, 1'b0}] = {d[AW-1:2], 2'b00};
        3'd1: m_sp[{t, 1'b1}] = {d[AW-1:2], 2'b00};
        3'd2: m_lim[{t, 1'b0}] = d;
        3'd3: m_lim[{t, 1'b1}] = d;
        3'd4: m_sel[t] = d[1];
        default: ;
      endcase
    end else if (v && !w && !ef) begin
      m_sp[b] = nsp;
    end
    chk(fault === ef, "R8 fault pulse", AW'(fault), AW'(ef));
    chk(asp === m_sp[exp_bank(s, h)], "R1/R2/R7 active pointer", asp, m_sp[exp_bank(s, h)]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h51AC_0042));
    for (int i = 0; i < 4; i++) begin m_sp[i] = '0; m_lim[i] = '0; end
    m_sel[0] = 1'b0; m_sel[1] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R3: reset state
    #1 chk(fault === 1'b0, "R3 fault low", AW'(fault), '0);
    chk(asp === '0, "R3 active zero", asp, '0);
    for (int c = 0; c < 16; c++) rd(1'b1, 4'(c), "R3/R4 reset read");

    // R9: no Non-secure limits on dut_nl
    step(1, 0, 1, 4'd10, 32'hFFFF_FFF0, 0, 0, 0);
    @(negedge clk); sec = 1'b1; sel = 4'd10; we = 1'b0;
    #1 chk(rdata_nl === '0, "R9 NS limit reads zero", rdata_nl, '0);
    step(1, 0, 1, 4'd10, 32'h0000_0000, 0, 0, 0);
    step(1, 0, 1, 4'd8, 32'h0000_0000, 0, 0, 0);
    step(0, 1, 0, 4'd0, '0, 1, 1, 4'd1);
    chk(fault_nl === 1'b0, "R9 no wrap fault", AW'(fault_nl), '0);
    chk(asp_nl === 32'hFFFF_FFFC, "R9 wrapped pointer", asp_nl, 32'hFFFF_FFFC);
    chk(fault === 1'b1, "R7 wrap faults with limits", AW'(fault), 32'd1);

    // R6: alignment of pointer writes
    step(1, 0, 1, 4'd0, 32'h0000_1003, 0, 0, 0);
    rd(1, 4'd0, "R6 aligned write");
    chk(rdata === 32'h0000_1000, "R6 value", rdata, 32'h0000_1000);

    // R1/R2: selection
    step(1, 0, 1, 4'd1, 32'h0000_2000, 0, 0, 0);
    step(1, 0, 1, 4'd4, 32'h0000_0002, 0, 0, 0);
    step(1, 0, 0, 4'd0, '0, 0, 0, 0);
    chk(asp === 32'h2000, "R2 thread uses process", asp, 32'h2000);
    step(1, 1, 0, 4'd0, '0, 0, 0, 0);
    chk(asp === 32'h1000, "R1 handler uses main", asp, 32'h1000);
    step(1, 0, 1, 4'd8, 32'h0000_0400, 0, 0, 0);
    step(0, 0, 0, 4'd0, '0, 0, 0, 0);
    chk(asp === 32'h0400, "R2 NS select bit separate", asp, 32'h0400);

    // R7/R8: boundary push on the Secure process stack
    step(1, 0, 1, 4'd3, 32'h0000_1FC4, 0, 0, 0);
    step(1, 0, 0, 4'd0, '0, 1, 1, 4'd15);
    chk(asp === 32'h1FC4 && fault === 1'b0, "R7 push to limit", asp, 32'h1FC4);
    step(1, 0, 0, 4'd0, '0, 1, 1, 4'd1);
    chk(asp === 32'h1FC4 && fault === 1'b1, "R8 push below limit", asp, 32'h1FC4);
    step(1, 0, 0, 4'd0, '0, 0, 0, 0);
    chk(fault === 1'b0, "R8 one-cycle pulse", AW'(fault), '0);

    // R5: alias from Non-secure state ignored
    step(0, 0, 1, 4'd8, 32'h0000_7770, 0, 0, 0);
    rd(0, 4'd8, "R5 alias read zero");
    rd(1, 4'd8, "R5 NS copy unchanged");

    // R10: write and operation together
    step(1, 0, 1, 4'd2, 32'h0, 1, 1, 4'd2);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] d;
      logic [3:0] c;
      d = ($urandom % 4 == 0) ? AW'($urandom % 64) : 32'h1000 + AW'($urandom % 256);
      c = 4'($urandom);
      rd(1'($urandom), 4'($urandom), "R4/R5 random read");
      step(1'($urandom), 1'($urandom), ($urandom % 3 == 0), c, d,
           1'($urandom), 1'($urandom), WW'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule